// File: doc/BRIEF.md
# 32-bit Integer Execute Unit

This block is the combinational execute stage of a 32-bit load/store RISC core. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit shift count and a decoded operation code, and it returns one 32-bit result. It does no storage and has no clock. The supported work covers modular add and subtract, the bitwise AND, OR and NOR functions, signed set-on-less-than, three shift kinds, the immediate forms of add, compare, AND and OR, and loading a constant into the upper half of a word.

Immediate widening happens inside the unit. The operation code decides how: the arithmetic and compare forms treat the immediate as a signed number, and the bitwise forms treat it as an unsigned bit pattern. Shifts always act on operand B. Operand A is used by every other operation except the upper-half load. Overflow is silent. Fetch, decode of the raw instruction word, the register file, traps, multiply/divide and floating point all sit in other blocks.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (subtract) gives A-B, both modulo 2^32, with no overflow signalling.
- R2: Code 2 gives A AND B, code 3 gives A OR B and code 4 gives the inverse of (A OR B), bit by bit.
- R3: Code 5 gives 1 when A is less than B as two's complement numbers, and 0 otherwise.
- R4: Code 6 shifts B left and code 7 shifts B right, each by shamt places (0 to 31), with zeros filling the vacated bits.
- R5: Code 8 shifts B right by shamt places and fills the vacated upper bits with copies of B[31].
- R6: Code 9 gives A plus the immediate and code 10 gives the signed less-than of A against the immediate. In both cases the immediate is sign-extended from bit 15.
- R7: Code 11 gives A AND the immediate and code 12 gives A OR the immediate. In both cases the immediate is zero-extended, so result bits 31:16 come from A alone (AND clears them, OR passes them).
- R8: Code 13 places the immediate in result bits 31:16 and clears bits 15:0. A, B and shamt have no effect.
- R9: Codes 14 and 15 are unsupported and give a result of zero whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Decoded operation code, values as in the requirements |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand; the value shifted by codes 6 to 8 |
| imm16 | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Shift count for codes 6 to 8 |
| result | output | 32 | Combinational result |

## Verification
The bench applies thousands of random operand sets over all sixteen codes. Operands are drawn from full-range words and also from a pool of edge values (0, 1, all ones, the two sign-boundary words), so that carries, borrows and sign changes are all exercised. Directed vectors then separate cases that random data rarely reaches. Signed and unsigned ordering are told apart by comparing across the sign boundary. Sign and zero extension of the immediate are told apart by using immediates with bit 15 set. Arithmetic and logical right shifts are told apart by shifting a negative word. Shift counts 0 and 31 test the ends of the shifter. The unsupported codes are driven with all-ones operands so that any leakage shows as a nonzero result.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_ADDI = 4'd9,
    OP_SLTI = 4'd10,
    OP_ANDI = 4'd11,
    OP_ORI  = 4'd12,
    OP_LUI  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } exu_op_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_NOR, FN_SLT
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_LEFT, SH_RIGHT_ZERO, SH_RIGHT_SIGN
  } sh_kind_e;

  typedef enum logic [1:0] {
    RES_ZERO, RES_ALU, RES_SHIFT, RES_UPPER
  } res_src_e;
endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm,
  input  logic          sign_mode,
  output logic [DW-1:0] ext,
  output logic [DW-1:0] upper
);
  localparam int PADW = DW - IW;

  function automatic logic [DW-1:0] widen(input logic [IW-1:0] v, input logic sgn);
    logic fill;
    fill = sgn & v[IW-1];
    return {{PADW{fill}}, v};
  endfunction

  assign ext   = widen(imm, sign_mode);
  assign upper = {imm, {PADW{1'b0}}};

  always_comb begin
    if (!sign_mode)
      a_r7_zero_pad: assert (ext[DW-1:IW] == '0);
    if (sign_mode && imm[IW-1])
      a_r6_sign_pad: assert (&ext[DW-1:IW]);
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
  import exu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  val,
  input  logic [SHW-1:0] amt,
  input  sh_kind_e       kind,
  output logic [DW-1:0]  res
);
  function automatic logic [DW-1:0] bit_rev(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  logic          is_left;
  logic          fill_bit;
  logic [DW-1:0] stage [SHW+1];

  assign is_left  = (kind == SH_LEFT);
  assign fill_bit = (kind == SH_RIGHT_SIGN) & val[DW-1];
  assign stage[0] = is_left ? bit_rev(val) : val;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill_bit}}, stage[s][DW-1:STEP]} : stage[s];
  end

  assign res = is_left ? bit_rev(stage[SHW]) : stage[SHW];

  always_comb begin
    if (kind == SH_RIGHT_ZERO && amt != '0)
      a_r4_right_zero_fill: assert (res[DW-1] == 1'b0);
    if (kind == SH_LEFT && amt != '0)
      a_r4_left_zero_fill: assert (res[0] == 1'b0);
    if (kind == SH_RIGHT_SIGN)
      a_r5_sign_kept: assert (res[DW-1] == val[DW-1]);
    if (amt == '0)
      a_r4_zero_count: assert (res == val);
  end
endmodule

// File: rtl/exu_alu_core.sv
module exu_alu_core
  import exu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_fn_e       fn,
  output logic [DW-1:0] res
);
  function automatic logic signed_less(input logic [DW-1:0] x, input logic [DW-1:0] y);
    if (x[DW-1] != y[DW-1]) return x[DW-1];
    return x < y;
  endfunction

  function automatic logic [DW-1:0] add_sub(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                            input logic sub);
    return x + (sub ? ~y : y) + {{(DW-1){1'b0}}, sub};
  endfunction

  logic [DW-1:0] sum;
  assign sum = add_sub(a, b, fn == FN_SUB);

  always_comb begin
    unique case (fn)
      FN_ADD, FN_SUB: res = sum;
      FN_AND:         res = a & b;
      FN_OR:          res = a | b;
      FN_NOR:         res = ~(a | b);
      FN_SLT:         res = {{(DW-1){1'b0}}, signed_less(a, b)};
      default:        res = '0;
    endcase
  end

  always_comb begin
    if (fn == FN_SLT)
      a_r3_bool_result: assert (res[DW-1:1] == '0);
    if (fn == FN_SUB && a == b)
      a_r1_self_sub_zero: assert (res == '0);
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IW  = 16,
  parameter int SHW = $clog2(DW)
) (
  input  logic [OPW-1:0] op_sel,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [IW-1:0]  imm16,
  input  logic [SHW-1:0] shamt,
  output logic [DW-1:0]  result
);
  exu_op_e       op;
  alu_fn_e       fn;
  sh_kind_e      sh_kind;
  res_src_e      src;
  logic          use_imm;
  logic          imm_signed;
  logic [DW-1:0] imm_ext, imm_upper, alu_b, alu_res, sh_res;

  assign op = exu_op_e'(op_sel);

  always_comb begin
    fn         = FN_ADD;
    sh_kind    = SH_LEFT;
    src        = RES_ALU;
    use_imm    = 1'b0;
    imm_signed = 1'b0;
    unique case (op)
      OP_ADD:  fn = FN_ADD;
      OP_SUB:  fn = FN_SUB;
      OP_AND:  fn = FN_AND;
      OP_OR:   fn = FN_OR;
      OP_NOR:  fn = FN_NOR;
      OP_SLT:  fn = FN_SLT;
      OP_SLL:  begin src = RES_SHIFT; sh_kind = SH_LEFT;       end
      OP_SRL:  begin src = RES_SHIFT; sh_kind = SH_RIGHT_ZERO; end
      OP_SRA:  begin src = RES_SHIFT; sh_kind = SH_RIGHT_SIGN; end
      OP_ADDI: begin fn = FN_ADD; use_imm = 1'b1; imm_signed = 1'b1; end
      OP_SLTI: begin fn = FN_SLT; use_imm = 1'b1; imm_signed = 1'b1; end
      OP_ANDI: begin fn = FN_AND; use_imm = 1'b1; end
      OP_ORI:  begin fn = FN_OR;  use_imm = 1'b1; end
      OP_LUI:  src = RES_UPPER;
      default: src = RES_ZERO;
    endcase
  end

  exu_imm_ext #(.DW(DW), .IW(IW)) ext_i (
    .imm(imm16), .sign_mode(imm_signed), .ext(imm_ext), .upper(imm_upper)
  );

  assign alu_b = use_imm ? imm_ext : opb;

  exu_alu_core #(.DW(DW)) alu_i (
    .a(opa), .b(alu_b), .fn(fn), .res(alu_res)
  );

  exu_shifter #(.DW(DW), .SHW(SHW)) sh_i (
    .val(opb), .amt(shamt), .kind(sh_kind), .res(sh_res)
  );

  always_comb begin
    unique case (src)
      RES_ALU:   result = alu_res;
      RES_SHIFT: result = sh_res;
      RES_UPPER: result = imm_upper;
      default:   result = '0;
    endcase
  end

  always_comb begin
    if (op == OP_RSV0 || op == OP_RSV1)
      a_r9_unsupported_zero: assert (result == '0);
    if (op == OP_LUI)
      a_r8_upper_load: assert (result[IW-1:0] == '0 && result[DW-1:DW-IW] == imm16);
    if (op == OP_ANDI)
      a_r7_andi_high_clear: assert (result[DW-1:IW] == '0);
    if (op == OP_ORI)
      a_r7_ori_high_pass: assert (result[DW-1:IW] == opa[DW-1:IW]);
  end
endmodule

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit dut_i (
    .op_sel(op_sel), .opa(opa), .opb(opb), .imm16(imm16), .shamt(shamt), .result(result)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R1";
      4'd2, 4'd3, 4'd4:  return "R2";
      4'd5:              return "R3";
      4'd6, 4'd7:        return "R4";
      4'd8:              return "R5";
      4'd9, 4'd10:       return "R6";
      4'd11, 4'd12:      return "R7";
      4'd13:             return "R8";
      default:           return "R9";
    endcase
  endfunction

  function automatic logic [31:0] shift_ref(input logic [31:0] v, input int n,
                                            input bit left, input bit arith);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (left)            r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
      else if (i + n < 32) r[i] = v[i+n];
      else                 r[i] = arith ? v[31] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [4:0] sh);
    longint sa, sb, si;
    logic [31:0] sx, zx;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(im));
    sx = 32'(si);
    zx = {16'h0000, im};
    case (op)
      4'd0:  return 32'(sa + sb);
      4'd1:  return 32'(sa - sb);
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return ~a & ~b;
      4'd5:  return (sa < sb) ? 32'd1 : 32'd0;
      4'd6:  return shift_ref(b, int'(sh), 1'b1, 1'b0);
      4'd7:  return shift_ref(b, int'(sh), 1'b0, 1'b0);
      4'd8:  return shift_ref(b, int'(sh), 1'b0, 1'b1);
      4'd9:  return a + sx;
      4'd10: return (sa < si) ? 32'd1 : 32'd0;
      4'd11: return a & zx;
      4'd12: return a | zx;
      4'd13: return im * 32'h0001_0000;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; imm16 = im; shamt = sh;
    #1;
    exp = model(op, a, b, im, sh);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d actual=%h expected=%h",
               tag, op, a, b, im, sh, result, exp);
    end
  endtask

  function automatic logic [31:0] pick_word();
    logic [31:0] pool [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    if ($urandom % 3 == 0) return pool[$urandom % 5];
    return $urandom;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // reset-like idle state: all-zero inputs give zero (R1 add of zeros)
    apply(4'd0, 32'h0, 32'h0, 16'h0, 5'd0, "R1 idle");
    // R1 wrap and borrow
    apply(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R1 add wrap");
    apply(4'd1, 32'h0, 32'h1, 16'h0, 5'd0, "R1 sub borrow");
    apply(4'd1, 32'h8000_0000, 32'h1, 16'h0, 5'd0, "R1 sub overflow");
    // R2 logic
    apply(4'd4, 32'h0F0F_0000, 32'h00F0_00FF, 16'h0, 5'd0, "R2 nor");
    apply(4'd2, 32'hB6A4_3D9A, 32'h0000_0FFF, 16'h0, 5'd0, "R2 and mask");
    // R3 signed vs unsigned ordering
    apply(4'd5, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R3 neg<pos");
    apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, "R3 max!<min");
    apply(4'd5, 32'h5, 32'h5, 16'h0, 5'd0, "R3 equal");
    // R4 / R5 shift ends and sign fill
    apply(4'd6, 32'hDEAD_BEEF, 32'h1234_5678, 16'h0, 5'd31, "R4 sll 31");
    apply(4'd7, 32'h0, 32'h8765_4321, 16'h0, 5'd0, "R4 srl 0");
    apply(4'd7, 32'h0, 32'h1234_5678, 16'h0, 5'd8, "R4 srl 8");
    apply(4'd8, 32'h0, 32'h9234_5678, 16'h0, 5'd8, "R5 sra neg");
    apply(4'd8, 32'h0, 32'h8000_0000, 16'h0, 5'd31, "R5 sra 31");
    apply(4'd8, 32'h0, 32'h1234_5678, 16'h0, 5'd8, "R5 sra pos");
    // R6 sign-extended immediates
    apply(4'd9, 32'd100, 32'h0, 16'hFFCE, 5'd0, "R6 addi -50");
    apply(4'd10, 32'h0, 32'h0, 16'h8000, 5'd0, "R6 slti vs neg");
    apply(4'd10, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0, "R6 slti -2<-1");
    // R7 zero-extended immediates
    apply(4'd12, 32'h1234_5678, 32'h0, 16'hFFFF, 5'd0, "R7 ori");
    apply(4'd11, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, "R7 andi");
    // R8 upper load ignores other inputs
    apply(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABAB, 5'd31, "R8 lui");
    // R9 unsupported codes
    apply(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, "R9 code14");
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, "R9 code15");
    // random sweep over all codes
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] op;
      op = 4'($urandom % 16);
      apply(op, pick_word(), pick_word(), 16'($urandom), 5'($urandom), req_of(op));
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule